// File: doc/BRIEF.md
# Delayed Coincidence Window Matcher

This block pairs two single-crossing pulse streams that run at the bunch-crossing rate. The first stream (the source, such as a local track flag or a data-available flag) is held back by a programmable whole number of crossings. Each delayed source pulse then opens a window a programmable number of crossings wide, and a pulse on the second stream (the accept) that lands inside that window forms a coincidence. A coincidence either starts a readout of the matched data or is passed on as a combined trigger. Typical settings are a delay of 128 crossings with a 3-crossing window for trigger acceptance, 8 crossings with a 3-crossing window for pairing two track types, and delays of 24, 4 or 21 crossings with a 2-crossing window for data-available pairing.

The window is placed around the nominal delayed arrival, with the spare crossing of an even width on the late side. For every coincidence the block reports which crossing of the window the accept fell in. A source pulse whose window closes with no accept gives a one-cycle unmatched pulse. Any change to the delay or width setting drops all pulses in flight, so that a stale pulse can never be paired under new timing.

Top module: `coinc_window_match`

## Requirements
- R1: While reset is held and in the first cycle after it, matchPulse and missPulse are 0 and matchOfs is 0.
- R2: With width W (a width setting of 0 counts as 1), early = floor((W-1)/2) and delay D, a source pulse sampled at edge s has its window over edges s+S to s+S+W-1, where S = D-early, or 0 when D < early; with W odd the nominal edge s+D is the centre crossing, with W even the extra crossing lies after it.
- R3: An accept sampled at an edge inside a pending source's window produces matchPulse high for exactly the cycle after that edge; an accept outside every pending window produces no matchPulse.
- R4: While matchPulse is high, matchOfs equals the accept edge minus the first edge of the matched window (0 is the first crossing of the window); it is 0 whenever matchPulse is low.
- R5: A source pulse whose window's last edge passes without it being matched produces missPulse high for exactly the cycle after that last edge.
- R6: When several unmatched source windows contain an accept, the accept matches the oldest source; each source matches at most one accept and each accept at most one source, so a second accept in the same window can only match a later source.
- R7: If delayCfg or widthCfg sampled at an edge differs from the value sampled at the previous edge, all pending source pulses and the source pulse at that edge are discarded, and matchPulse and missPulse are 0 in the following cycle.
- R8: With delay 0 and width 0 or 1, a source and an accept at the same edge match with matchOfs 0; with a delay below early the window starts at the source's own edge and keeps its full width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing-rate clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcPulse | input | 1 | Source stream, delayed before windowing |
| accPulse | input | 1 | Accept stream, searched within windows |
| delayCfg | input | 8 | Delay in whole crossings, 0 to 255 |
| widthCfg | input | 4 | Window width in crossings, 0 treated as 1 |
| matchPulse | output | 1 | One-cycle coincidence pulse |
| missPulse | output | 1 | One-cycle pulse for a source whose window closed unmatched |
| matchOfs | output | 4 | Crossing within the window where the match occurred |

## Verification
The hardest situation to reach is contention: several source windows open at once, accepts landing where they overlap, and a window retiring in the same crossing as an accept picks an older source, together with a setting change arriving while pulses are still in flight. Directed sequences place back-to-back sources and paired accepts at exact offsets, including the last crossing of a window, and change the setting mid-window. Seeded random traffic with dense accepts is then run under each of the typical delay and width settings, long enough for the 128-crossing delay to fill, with every cycle compared against an age-indexed model of pending sources.

// File: rtl/cwm_pkg.sv
package cwm_pkg;
  localparam int DLY_W   = 8;
  localparam int WID_W   = 4;
  localparam int MAXW    = (1 << WID_W) - 1;
  localparam int DLY_LEN = 1 << DLY_W;

  typedef struct packed {
    logic             flush;
    logic             tapZero;
    logic [DLY_W-1:0] tapIdx;
  } cwm_strobe_t;
endpackage

// File: rtl/cwm_pipe.sv
module cwm_pipe
  import cwm_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            srcPulse,
  input  cwm_strobe_t     strobe,
  input  logic [MAXW-1:0] dropMask,
  output logic [MAXW-1:0] cand
);
  logic [DLY_LEN-1:0] dlyLine;
  logic [MAXW-2:0]    winAge;
  logic               openNow;

  assign openNow = strobe.tapZero ? srcPulse : dlyLine[strobe.tapIdx];
  assign cand    = {winAge, openNow};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dlyLine <= '0;
    end else if (strobe.flush) begin
      dlyLine <= '0;
    end else begin
      dlyLine <= {dlyLine[DLY_LEN-2:0], srcPulse};
    end
  end

  // One stage per window crossing: a pending pulse ages by one each edge.
  for (genvar k = 0; k < MAXW - 1; k++) begin : g_win
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        winAge[k] <= 1'b0;
      end else if (strobe.flush) begin
        winAge[k] <= 1'b0;
      end else begin
        winAge[k] <= cand[k] & ~dropMask[k];
      end
    end
  end
endmodule

// File: rtl/cwm_ctrl.sv
module cwm_ctrl
  import cwm_pkg::*;
#(
  parameter int DEF_DELAY = 128,
  parameter int DEF_WIDTH = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DLY_W-1:0] delayCfg,
  input  logic [WID_W-1:0] widthCfg,
  input  logic             accPulse,
  input  logic [MAXW-1:0]  cand,
  output cwm_strobe_t      strobe,
  output logic [MAXW-1:0]  dropMask,
  output logic             matchPulse,
  output logic             missPulse,
  output logic [WID_W-1:0] matchOfs
);
  logic [DLY_W-1:0] delayReg;
  logic [WID_W-1:0] widthReg;
  logic [WID_W-1:0] widthEff;
  logic [WID_W-1:0] earlyCnt;
  logic [DLY_W:0]   startOfs;
  logic             cfgChange;
  logic             found;
  logic [WID_W-1:0] pickIdx;
  logic             missNow;

  assign cfgChange = (delayCfg != delayReg) || (widthCfg != widthReg);
  assign widthEff  = (widthReg == '0) ? WID_W'(1) : widthReg;
  assign earlyCnt  = (widthEff - WID_W'(1)) >> 1;

  always_comb begin
    if ({1'b0, delayReg} >= {{(DLY_W + 1 - WID_W){1'b0}}, earlyCnt})
      startOfs = {1'b0, delayReg} - {{(DLY_W + 1 - WID_W){1'b0}}, earlyCnt};
    else
      startOfs = '0;
  end

  always_comb begin
    strobe.flush   = cfgChange;
    strobe.tapZero = (startOfs == '0);
    strobe.tapIdx  = DLY_W'(startOfs - (DLY_W + 1)'(1));
  end

  // Oldest pending window position inside the current width wins.
  always_comb begin
    found   = 1'b0;
    pickIdx = '0;
    if (accPulse) begin
      for (int k = 0; k < MAXW; k++) begin
        if (cand[k] && (k < int'(widthEff))) begin
          found   = 1'b1;
          pickIdx = WID_W'(k);
        end
      end
    end
  end

  always_comb begin
    missNow = cand[widthEff - WID_W'(1)] && !(found && (pickIdx == widthEff - WID_W'(1)));
    for (int k = 0; k < MAXW; k++) begin
      dropMask[k] = (found && (k == int'(pickIdx))) || (k >= int'(widthEff) - 1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      delayReg   <= DLY_W'(DEF_DELAY);
      widthReg   <= WID_W'(DEF_WIDTH);
      matchPulse <= 1'b0;
      missPulse  <= 1'b0;
      matchOfs   <= '0;
    end else begin
      delayReg <= delayCfg;
      widthReg <= widthCfg;
      if (cfgChange) begin
        matchPulse <= 1'b0;
        missPulse  <= 1'b0;
        matchOfs   <= '0;
      end else begin
        matchPulse <= found;
        missPulse  <= missNow;
        matchOfs   <= found ? pickIdx : '0;
      end
    end
  end
endmodule

// File: rtl/coinc_window_match.sv
module coinc_window_match
  import cwm_pkg::*;
#(
  parameter int DEF_DELAY = 128,
  parameter int DEF_WIDTH = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             srcPulse,
  input  logic             accPulse,
  input  logic [DLY_W-1:0] delayCfg,
  input  logic [WID_W-1:0] widthCfg,
  output logic             matchPulse,
  output logic             missPulse,
  output logic [WID_W-1:0] matchOfs
);
  cwm_strobe_t     strobe;
  logic [MAXW-1:0] cand;
  logic [MAXW-1:0] dropMask;

  cwm_pipe i_pipe (
    .clk      (clk),
    .rstN     (rstN),
    .srcPulse (srcPulse),
    .strobe   (strobe),
    .dropMask (dropMask),
    .cand     (cand)
  );

  cwm_ctrl #(
    .DEF_DELAY (DEF_DELAY),
    .DEF_WIDTH (DEF_WIDTH)
  ) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .delayCfg   (delayCfg),
    .widthCfg   (widthCfg),
    .accPulse   (accPulse),
    .cand       (cand),
    .strobe     (strobe),
    .dropMask   (dropMask),
    .matchPulse (matchPulse),
    .missPulse  (missPulse),
    .matchOfs   (matchOfs)
  );
endmodule

// File: rtl/cwm_checker.sv
module cwm_checker
  import cwm_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             srcPulse,
  input logic             accPulse,
  input logic [DLY_W-1:0] delayCfg,
  input logic [WID_W-1:0] widthCfg,
  input logic             matchPulse,
  input logic             missPulse,
  input logic [WID_W-1:0] matchOfs
);
  AST_MATCH_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    matchPulse |-> $past(accPulse)); // R3

  AST_OFS_WITHIN_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    matchPulse |-> (matchOfs < (($past(widthCfg) == '0) ? WID_W'(1) : $past(widthCfg)))); // R4

  AST_OFS_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !matchPulse |-> (matchOfs == '0)); // R4

  AST_FLUSH_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && ((delayCfg != $past(delayCfg)) || (widthCfg != $past(widthCfg))))
      |=> (!matchPulse && !missPulse)); // R7

  AST_ZERO_DELAY_SAME_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    (matchPulse && $past(delayCfg) == '0 && $past(widthCfg) <= WID_W'(1))
      |-> ($past(srcPulse) && matchOfs == '0)); // R8
endmodule

bind coinc_window_match cwm_checker i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .srcPulse   (srcPulse),
  .accPulse   (accPulse),
  .delayCfg   (delayCfg),
  .widthCfg   (widthCfg),
  .matchPulse (matchPulse),
  .missPulse  (missPulse),
  .matchOfs   (matchOfs)
);

// File: tb/test_coinc_window_match.sv
module test_coinc_window_match;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       srcPulse = 1'b0;
  logic       accPulse = 1'b0;
  logic [7:0] delayCfg = 8'd128;
  logic [3:0] widthCfg = 4'd3;
  logic       matchPulse;
  logic       missPulse;
  logic [3:0] matchOfs;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  bit [299:0] hist;
  int prevD = 128;
  int prevW = 3;
  bit expM, expX;
  int expO;

  always #10 clk = ~clk;

  coinc_window_match i_coinc_window_match (
    .clk(clk), .rstN(rstN), .srcPulse(srcPulse), .accPulse(accPulse),
    .delayCfg(delayCfg), .widthCfg(widthCfg),
    .matchPulse(matchPulse), .missPulse(missPulse), .matchOfs(matchOfs)
  );

  function automatic int effWidth(int w);
    return (w == 0) ? 1 : w;
  endfunction

  function automatic int winStart(int d, int w);
    int early = (effWidth(w) - 1) / 2;
    return (d >= early) ? d - early : 0;
  endfunction

  // Reference model over source ages at one sampling edge.
  task automatic modelEdge(bit s, bit a, int d, int w);
    int st, we;
    expM = 0; expX = 0; expO = 0;
    if (d != prevD || w != prevW) begin
      hist = '0; prevD = d; prevW = w;
      return;
    end
    we = effWidth(w);
    st = winStart(d, w);
    hist = {hist[298:0], s};
    if (a) begin
      for (int k = st + we - 1; k >= st; k--) begin
        if (hist[k] && !expM) begin
          expM = 1; expO = k - st; hist[k] = 0;
        end
      end
    end
    expX = hist[st + we - 1];
    hist[st + we - 1] = 0;
  endtask

  task automatic step(bit s, bit a, string tag);
    srcPulse = s; accPulse = a;
    @(posedge clk);
    modelEdge(s, a, int'(delayCfg), int'(widthCfg));
    @(negedge clk);
    checks++;
    if (matchPulse !== expM || missPulse !== expX || int'(matchOfs) != expO) begin
      fails++;
      $display("FAIL %s: match=%0b miss=%0b ofs=%0d expected match=%0b miss=%0b ofs=%0d",
               tag, matchPulse, missPulse, matchOfs, expM, expX, expO);
    end
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(0, 0, tag);
  endtask

  task automatic setCfg(int d, int w, string tag);
    delayCfg = 8'(d); widthCfg = 4'(w);
    step(0, 0, tag);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;  // R1 during reset
    if (matchPulse !== 1'b0 || missPulse !== 1'b0 || matchOfs !== 4'd0) begin
      fails++;
      $display("FAIL R1: match=%0b miss=%0b ofs=%0d expected 0 0 0", matchPulse, missPulse, matchOfs);
    end
    rstN = 1'b1;
    step(0, 0, "R1");

    // Delay 8 width 3: window edges s+7..s+9, centre at s+8
    setCfg(8, 3, "R7");
    step(1, 0, "R2"); idle(7, "R2"); step(0, 1, "R2 centre ofs1"); idle(4, "R2");
    step(1, 0, "R4"); idle(6, "R4"); step(0, 1, "R4 first ofs0"); idle(4, "R4");
    step(1, 0, "R4"); idle(8, "R4"); step(0, 1, "R4 last ofs2"); idle(4, "R4");
    // Accepts just outside the window
    step(1, 0, "R3"); idle(5, "R3"); step(0, 1, "R3 early"); idle(3, "R5");
    step(0, 1, "R3 late"); idle(3, "R3");
    // Unmatched source
    step(1, 0, "R5"); idle(12, "R5");
    // Two sources back to back, two accepts in overlap
    step(1, 0, "R6"); step(1, 0, "R6"); idle(6, "R6");
    step(0, 1, "R6 oldest"); step(0, 1, "R6 second"); idle(4, "R6");
    // Accept at the oldest window's last edge
    step(1, 0, "R6"); step(1, 0, "R6"); idle(7, "R6");
    step(0, 1, "R6 retire edge"); idle(4, "R6");
    // Two accepts, one source: only one match
    step(1, 0, "R6"); idle(6, "R6"); step(0, 1, "R6"); step(0, 1, "R6 no reuse"); idle(4, "R6");
    // Even width: window s+4..s+5 for delay 4 width 2
    setCfg(4, 2, "R7");
    step(1, 0, "R2"); idle(4, "R2"); step(0, 1, "R2 even late side"); idle(3, "R2");
    step(1, 0, "R2"); idle(3, "R2"); step(0, 1, "R2 before centre"); idle(4, "R5");
    // Setting change mid-flight
    step(1, 0, "R7"); step(1, 0, "R7"); idle(2, "R7");
    delayCfg = 8'd5; step(1, 1, "R7 change edge");
    idle(12, "R7");
    // Delay 0 width 0 and 1
    setCfg(0, 0, "R8");
    step(1, 1, "R8 same edge"); step(1, 0, "R8"); step(0, 1, "R8"); idle(2, "R8");
    setCfg(0, 1, "R8");
    step(1, 1, "R8 same edge"); idle(2, "R8");
    // Delay below early: width 7, early 3, delay 1 -> window s..s+6
    setCfg(1, 7, "R8");
    step(1, 1, "R8 own edge"); step(1, 0, "R8"); idle(5, "R8"); step(0, 1, "R8 last"); idle(3, "R8");

    // Seeded random traffic over typical settings
    void'($urandom(32'h1c0ffee));
    for (int blk = 0; blk < 7; blk++) begin
      int d, w;
      case (blk)
        0: begin d = 128; w = 3; end
        1: begin d = 8;   w = 3; end
        2: begin d = 24;  w = 2; end
        3: begin d = 4;   w = 2; end
        4: begin d = 21;  w = 2; end
        5: begin d = 255; w = 15; end
        default: begin d = int'($urandom_range(0, 40)); w = int'($urandom_range(0, 15)); end
      endcase
      setCfg(d, w, "R7");
      for (int i = 0; i < 500; i++) begin
        bit s = ($urandom_range(0, 5) == 0);
        bit a = ($urandom_range(0, 3) == 0);
        step(s, a, "R3 random");
      end
    end
    finishRun();
  end
endmodule